// File: doc/BRIEF.md
# Link Power Management Request Sequencer

This block is the host-side engine that puts a locally attached USB device into the light-sleep link state. Software writes three things in a single write: a launch bit, a 3-bit budget of extra attempts and a 4-bit channel selector. If a port is connected, the block captures the budget and the selector. It looks up the device address and endpoint number stored for that channel in a small table. It then asks a stub token transmitter for two tokens in turn: an extended token, then the power management token. After that it waits for the device's handshake.

ACK, NYET and STALL are final answers. They end the sequence, pulse `done` and latch the answer in `result`. Any other response code, and also silence that lasts longer than a fixed timeout, counts as a failed attempt. After a failed attempt the two-token exchange is repeated while budget remains. When the budget is spent, the sequence ends with the outcome "exhausted". The launch bit reads back as `busy` and clears on its own. The number of attempts still left is visible at all times on `retries_left`.

Top module: `lpm_seq_top`

## Requirements
- R1: A write with `cfg_start`=1 while idle and with `port_connected`=1 sets `busy` one cycle later. `tok_valid` then shows an extended token (`tok_kind`=0). After that token is accepted, it shows the power management token (`tok_kind`=1). After the second acceptance, `tok_valid` drops while the block waits for a response.
- R2: A response code of 0 (ACK), 1 (NYET) or 2 (STALL) received while waiting ends the sequence on that clock edge. On that edge `busy` clears, `done` is high for exactly one cycle and `result` takes the same code value.
- R3: A response code of 3 (ERROR), any code from 4 to 7, or no response within `RSP_TIMEOUT` cycles of waiting counts as a failed attempt. If `retries_left` is nonzero, the block starts a new extended token on that edge and decrements `retries_left` by one.
- R4: At launch, `retries_left` is loaded with `cfg_retry`. When the attempt made with `retries_left`=0 fails, the sequence ends with `done` high, `result`=3 (exhausted) and `retries_left`=0. The total number of attempts is therefore `cfg_retry`+1.
- R5: `tbl_wr` stores `tbl_dev` and `tbl_ep` into the channel entry selected by `tbl_sel`. Every token of a sequence carries, on `tok_dev` and `tok_ep`, the entry of the channel that was given at launch.
- R6: A launch write made while `port_connected`=0 has no effect: `busy` and `tok_valid` stay low.
- R7: A write made while `busy` is high has no effect on the sequence in progress. This holds even if the write carries a launch bit, a new budget or a new channel. The running sequence keeps its channel and its retry count.
- R8: While `tok_valid` is high and `tok_ready` is low, the offered token (kind, address and endpoint) is held unchanged.
- R9: After reset, `busy`, `tok_valid` and `done` are low, and `retries_left` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_connected | input | 1 | A device is attached to the local port |
| cfg_wr | input | 1 | Control write strobe |
| cfg_start | input | 1 | Launch bit of the control write |
| cfg_retry | input | 3 | Extra attempts allowed after a failed one |
| cfg_chan | input | 4 | Channel whose address and endpoint are used |
| tbl_wr | input | 1 | Channel table write strobe |
| tbl_sel | input | 4 | Channel entry to write |
| tbl_dev | input | 7 | Device address to store |
| tbl_ep | input | 4 | Endpoint number to store |
| tok_valid | output | 1 | Token request to the transmitter |
| tok_ready | input | 1 | Transmitter accepts the current token |
| tok_kind | output | 1 | 0 = extended token, 1 = power management token |
| tok_dev | output | 7 | Device address carried by the token |
| tok_ep | output | 4 | Endpoint number carried by the token |
| rsp_valid | input | 1 | A response code is present |
| rsp_code | input | 3 | Response code: 0 ACK, 1 NYET, 2 STALL, 3 ERROR, 4-7 other |
| busy | output | 1 | Launch bit readback; high while a sequence runs |
| retries_left | output | 3 | Attempts still available in the current sequence |
| done | output | 1 | One-cycle pulse when a sequence ends |
| result | output | 2 | Final outcome: 0 ACK, 1 NYET, 2 STALL, 3 exhausted |

## Verification
The hardest situation to reach is the final attempt of a long sequence. The retry count has to fall to zero through a mix of failure kinds: the ERROR code, unassigned codes and pure timeouts. Only then does the last failure turn into an exhausted outcome instead of another token. The bench gets there by sweeping every budget from 0 to 7 against every number of failures from none up to one past the budget. It rotates the kind of failure from attempt to attempt and computes the expected count after each one. Writes that arrive in the middle of a sequence, and a transmitter that stalls on each token, are added on top of that sweep.

// File: rtl/lpm_seq_pkg.sv
package lpm_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_EXT  = 2'd1,
      ST_LPM  = 2'd2,
      ST_WAIT = 2'd3
   } seq_state_t;

   typedef enum logic [1:0] {
      RES_ACK     = 2'd0,
      RES_NYET    = 2'd1,
      RES_STALL   = 2'd2,
      RES_EXHAUST = 2'd3
   } seq_result_t;

   localparam logic [2:0] RSP_ACK   = 3'd0;
   localparam logic [2:0] RSP_NYET  = 3'd1;
   localparam logic [2:0] RSP_STALL = 3'd2;
   localparam logic [2:0] RSP_ERROR = 3'd3;

   localparam logic TOK_EXT = 1'b0;
   localparam logic TOK_LPM = 1'b1;

endpackage

// File: rtl/lpm_chan_table.sv
module lpm_chan_table #(
   parameter int NUM_CH    = 16,
   parameter int ADDR_W    = 7,
   parameter int EP_W      = 4,
   parameter bit RESET_TBL = 1'b1,
   localparam int CH_W     = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CH_W-1:0]   wr_sel,
   input  logic [ADDR_W-1:0] wr_dev,
   input  logic [EP_W-1:0]   wr_ep,
   input  logic [CH_W-1:0]   rd_sel,
   output logic [ADDR_W-1:0] rd_dev,
   output logic [EP_W-1:0]   rd_ep
);

   logic [ADDR_W-1:0] dev_q [NUM_CH];
   logic [EP_W-1:0]   ep_q  [NUM_CH];

   for (genvar g = 0; g < NUM_CH; g++) begin : g_entry
      logic hit;
      assign hit = wr_en && (wr_sel == CH_W'(g));
      if (RESET_TBL) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dev_q[g] <= '0;
               ep_q[g]  <= '0;
            end else if (hit) begin
               dev_q[g] <= wr_dev;
               ep_q[g]  <= wr_ep;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit) begin
               dev_q[g] <= wr_dev;
               ep_q[g]  <= wr_ep;
            end
         end
      end
   end

   assign rd_dev = dev_q[rd_sel];
   assign rd_ep  = ep_q[rd_sel];

endmodule

// File: rtl/lpm_rsp_class.sv
module lpm_rsp_class
   import lpm_seq_pkg::*;
(
   input  logic [2:0]  code,
   output logic        is_final,
   output seq_result_t fin_res
);

   always_comb begin
      is_final = 1'b1;
      fin_res  = RES_ACK;
      unique case (code)
         RSP_ACK:   fin_res = RES_ACK;
         RSP_NYET:  fin_res = RES_NYET;
         RSP_STALL: fin_res = RES_STALL;
         default: begin
            is_final = 1'b0;
            fin_res  = RES_EXHAUST;
         end
      endcase
   end

endmodule

// File: rtl/lpm_seq_fsm.sv
module lpm_seq_fsm
   import lpm_seq_pkg::*;
#(
   parameter int CH_W        = 4,
   parameter int RETRY_W     = 3,
   parameter int RSP_TIMEOUT = 64,
   localparam int TO_W       = $clog2(RSP_TIMEOUT + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_go,
   input  logic [RETRY_W-1:0] start_retry,
   input  logic [CH_W-1:0]    start_chan,
   input  logic               tok_ready,
   input  logic               rsp_valid,
   input  logic               rsp_final,
   input  seq_result_t        rsp_res,
   output logic               busy,
   output logic               tok_valid,
   output logic               tok_kind,
   output logic [CH_W-1:0]    chan_q,
   output logic [RETRY_W-1:0] retries_left,
   output logic               done,
   output seq_result_t        result
);

   localparam logic [TO_W-1:0] TO_LAST = TO_W'(RSP_TIMEOUT - 1);

   seq_state_t      state;
   logic [TO_W-1:0] to_cnt;
   logic            attempt_err;
   logic            wait_final;

   assign wait_final  = rsp_valid && rsp_final;
   assign attempt_err = (rsp_valid && !rsp_final) || (!rsp_valid && to_cnt == TO_LAST);

   assign busy      = (state != ST_IDLE);
   assign tok_valid = (state == ST_EXT) || (state == ST_LPM);
   assign tok_kind  = (state == ST_LPM) ? TOK_LPM : TOK_EXT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         to_cnt       <= '0;
         chan_q       <= '0;
         retries_left <= '0;
         done         <= 1'b0;
         result       <= RES_ACK;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start_go) begin
                  state        <= ST_EXT;
                  chan_q       <= start_chan;
                  retries_left <= start_retry;
               end
            end
            ST_EXT: begin
               if (tok_ready) state <= ST_LPM;
            end
            ST_LPM: begin
               if (tok_ready) begin
                  state  <= ST_WAIT;
                  to_cnt <= '0;
               end
            end
            ST_WAIT: begin
               if (wait_final) begin
                  state  <= ST_IDLE;
                  done   <= 1'b1;
                  result <= rsp_res;
               end else if (attempt_err) begin
                  if (retries_left == '0) begin
                     state  <= ST_IDLE;
                     done   <= 1'b1;
                     result <= RES_EXHAUST;
                  end else begin
                     state        <= ST_EXT;
                     retries_left <= retries_left - RETRY_W'(1);
                  end
               end else begin
                  to_cnt <= to_cnt + TO_W'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/lpm_seq_top.sv
module lpm_seq_top
   import lpm_seq_pkg::*;
#(
   parameter int NUM_CH      = 16,
   parameter int ADDR_W      = 7,
   parameter int EP_W        = 4,
   parameter int RETRY_W     = 3,
   parameter int RSP_TIMEOUT = 64,
   parameter bit RESET_TBL   = 1'b1,
   localparam int CH_W       = $clog2(NUM_CH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               port_connected,
   input  logic               cfg_wr,
   input  logic               cfg_start,
   input  logic [RETRY_W-1:0] cfg_retry,
   input  logic [CH_W-1:0]    cfg_chan,
   input  logic               tbl_wr,
   input  logic [CH_W-1:0]    tbl_sel,
   input  logic [ADDR_W-1:0]  tbl_dev,
   input  logic [EP_W-1:0]    tbl_ep,
   output logic               tok_valid,
   input  logic               tok_ready,
   output logic               tok_kind,
   output logic [ADDR_W-1:0]  tok_dev,
   output logic [EP_W-1:0]    tok_ep,
   input  logic               rsp_valid,
   input  logic [2:0]         rsp_code,
   output logic               busy,
   output logic [RETRY_W-1:0] retries_left,
   output logic               done,
   output logic [1:0]         result
);

   initial begin
      assert (NUM_CH >= 2 && (1 << CH_W) == NUM_CH)
         else $error("NUM_CH must be a power of two, at least 2");
      assert (RSP_TIMEOUT >= 2) else $error("RSP_TIMEOUT must be at least 2");
      assert (RETRY_W >= 1) else $error("RETRY_W must be at least 1");
      assert (ADDR_W >= 1 && EP_W >= 1) else $error("token field widths must be positive");
   end

   logic            start_go;
   logic            rsp_final;
   seq_result_t     rsp_res;
   seq_result_t     res_q;
   logic [CH_W-1:0] chan_q;

   assign start_go = cfg_wr && cfg_start && port_connected && !busy;

   lpm_chan_table #(
      .NUM_CH    (NUM_CH),
      .ADDR_W    (ADDR_W),
      .EP_W      (EP_W),
      .RESET_TBL (RESET_TBL)
   ) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (tbl_wr),
      .wr_sel (tbl_sel),
      .wr_dev (tbl_dev),
      .wr_ep  (tbl_ep),
      .rd_sel (chan_q),
      .rd_dev (tok_dev),
      .rd_ep  (tok_ep)
   );

   lpm_rsp_class u_class (
      .code     (rsp_code),
      .is_final (rsp_final),
      .fin_res  (rsp_res)
   );

   lpm_seq_fsm #(
      .CH_W        (CH_W),
      .RETRY_W     (RETRY_W),
      .RSP_TIMEOUT (RSP_TIMEOUT)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_go     (start_go),
      .start_retry  (cfg_retry),
      .start_chan   (cfg_chan),
      .tok_ready    (tok_ready),
      .rsp_valid    (rsp_valid),
      .rsp_final    (rsp_final),
      .rsp_res      (rsp_res),
      .busy         (busy),
      .tok_valid    (tok_valid),
      .tok_kind     (tok_kind),
      .chan_q       (chan_q),
      .retries_left (retries_left),
      .done         (done),
      .result       (res_q)
   );

   assign result = res_q;

endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk #(
   parameter int RETRY_W = 3,
   parameter int ADDR_W  = 7,
   parameter int EP_W    = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               port_connected,
   input logic               tok_valid,
   input logic               tok_ready,
   input logic               tok_kind,
   input logic [ADDR_W-1:0]  tok_dev,
   input logic [EP_W-1:0]    tok_ep,
   input logic               busy,
   input logic [RETRY_W-1:0] retries_left,
   input logic               done,
   input logic [1:0]         result
);

   a_r1_ext_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> tok_valid && tok_kind == 1'b0);

   a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !tok_valid);

   a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r3_left_step: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |->
         (retries_left == $past(retries_left)) ||
         (retries_left == $past(retries_left) - RETRY_W'(1)));

   a_r4_exhaust_zero: assert property (@(posedge clk) disable iff (!rst_n)
      done && result == 2'd3 |-> retries_left == '0);

   a_r6_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !port_connected |=> !busy);

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid && !tok_ready |=>
         tok_valid && $stable(tok_kind) && $stable(tok_dev) && $stable(tok_ep));

endmodule

bind lpm_seq_top lpm_seq_chk #(
   .RETRY_W (RETRY_W),
   .ADDR_W  (ADDR_W),
   .EP_W    (EP_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .port_connected (port_connected),
   .tok_valid      (tok_valid),
   .tok_ready      (tok_ready),
   .tok_kind       (tok_kind),
   .tok_dev        (tok_dev),
   .tok_ep         (tok_ep),
   .busy           (busy),
   .retries_left   (retries_left),
   .done           (done),
   .result         (result)
);

// File: tb/tb_lpm_seq_top.sv
`timescale 1ns/1ps
module tb_lpm_seq_top;

   localparam int TO = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       port_connected = 1'b1;
   logic       cfg_wr = 1'b0, cfg_start = 1'b0;
   logic [2:0] cfg_retry = '0;
   logic [3:0] cfg_chan = '0;
   logic       tbl_wr = 1'b0;
   logic [3:0] tbl_sel = '0;
   logic [6:0] tbl_dev = '0;
   logic [3:0] tbl_ep = '0;
   logic       tok_valid, tok_ready = 1'b1, tok_kind;
   logic [6:0] tok_dev;
   logic [3:0] tok_ep;
   logic       rsp_valid = 1'b0;
   logic [2:0] rsp_code = '0;
   logic       busy, done;
   logic [2:0] retries_left;
   logic [1:0] result;

   int n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   lpm_seq_top #(.RSP_TIMEOUT(TO)) dut (
      .clk(clk), .rst_n(rst_n), .port_connected(port_connected),
      .cfg_wr(cfg_wr), .cfg_start(cfg_start), .cfg_retry(cfg_retry), .cfg_chan(cfg_chan),
      .tbl_wr(tbl_wr), .tbl_sel(tbl_sel), .tbl_dev(tbl_dev), .tbl_ep(tbl_ep),
      .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_kind(tok_kind),
      .tok_dev(tok_dev), .tok_ep(tok_ep), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
      .busy(busy), .retries_left(retries_left), .done(done), .result(result)
   );

   function automatic logic [6:0] exp_dev(int c);
      return 7'((c * 5 + 3) % 128);
   endfunction
   function automatic logic [3:0] exp_ep(int c);
      return 4'((c * 3 + 1) % 16);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_tok(input logic kind, input int c, input string req);
      chk(tok_valid === 1'b1, {req, " tok_valid"}, int'(tok_valid), 1);
      chk(tok_kind === kind, {req, " tok_kind"}, int'(tok_kind), int'(kind));
      chk(tok_dev === exp_dev(c), {req, " tok_dev"}, int'(tok_dev), int'(exp_dev(c)));
      chk(tok_ep === exp_ep(c), {req, " tok_ep"}, int'(tok_ep), int'(exp_ep(c)));
   endtask

   task automatic launch(input int r, input int c);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_start = 1'b1; cfg_retry = 3'(r); cfg_chan = 4'(c);
      @(negedge clk);
      cfg_wr = 1'b0; cfg_start = 1'b0;
   endtask

   // one sequence: n_err failed attempts, then final code fin (if budget allows)
   task automatic run_seq(input int r, input int c, input int n_err, input int fin,
                          input bit mid_write);
      bit ended = 1'b0;
      launch(r, c);
      chk(busy === 1'b1, "R1 busy after launch", int'(busy), 1);
      chk(retries_left === 3'(r), "R4 load retries_left", int'(retries_left), r);
      for (int a = 0; a <= r && !ended; a++) begin
         chk_tok(1'b0, c, "R1/R5 ext token");
         @(negedge clk);
         chk_tok(1'b1, c, "R1/R5 lpm token");
         if (mid_write && a == 0) begin
            cfg_wr = 1'b1; cfg_start = 1'b1;
            cfg_retry = ~3'(r); cfg_chan = 4'(c + 1);
         end
         @(negedge clk);
         cfg_wr = 1'b0; cfg_start = 1'b0;
         chk(tok_valid === 1'b0, "R1 idle while waiting", int'(tok_valid), 0);
         if (mid_write && a == 0)
            chk(retries_left === 3'(r), "R7 write ignored", int'(retries_left), r);
         if (a < n_err) begin
            int sel = (a + r) % 6;
            if (sel < 5) begin
               rsp_valid = 1'b1; rsp_code = 3'(3 + sel);
               @(negedge clk);
               rsp_valid = 1'b0;
            end else begin
               repeat (TO - 1) @(negedge clk);
               chk(busy === 1'b1 && tok_valid === 1'b0, "R3 no early timeout",
                   int'(tok_valid), 0);
               @(negedge clk);
            end
            if (a == r) begin
               chk(done === 1'b1, "R4 done on exhaust", int'(done), 1);
               chk(result === 2'd3, "R4 result exhausted", int'(result), 3);
               chk(retries_left === 3'd0, "R4 retries_left zero", int'(retries_left), 0);
               chk(busy === 1'b0, "R4 busy cleared", int'(busy), 0);
               ended = 1'b1;
            end else begin
               chk(busy === 1'b1, "R3 retry keeps busy", int'(busy), 1);
               chk(retries_left === 3'(r - a - 1), "R3 decrement",
                   int'(retries_left), r - a - 1);
            end
         end else begin
            rsp_valid = 1'b1; rsp_code = 3'(fin);
            @(negedge clk);
            rsp_valid = 1'b0;
            chk(done === 1'b1, "R2 done pulse", int'(done), 1);
            chk(result === 2'(fin), "R2 result code", int'(result), fin);
            chk(busy === 1'b0, "R2 busy cleared", int'(busy), 0);
            chk(retries_left === 3'(r - a), "R2 retries_left held",
                int'(retries_left), r - a);
            ended = 1'b1;
         end
      end
      @(negedge clk);
      chk(done === 1'b0, "R2 done one cycle", int'(done), 0);
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(busy === 1'b0, "R9 busy", int'(busy), 0);
      chk(tok_valid === 1'b0, "R9 tok_valid", int'(tok_valid), 0);
      chk(done === 1'b0, "R9 done", int'(done), 0);
      chk(retries_left === 3'd0, "R9 retries_left", int'(retries_left), 0);
      chk(result === 2'd0, "R9 result", int'(result), 0);

      // R5 program the channel table
      for (int i = 0; i < 16; i++) begin
         tbl_wr = 1'b1; tbl_sel = 4'(i); tbl_dev = exp_dev(i); tbl_ep = exp_ep(i);
         @(negedge clk);
      end
      tbl_wr = 1'b0;

      // R6 launch ignored with no port
      port_connected = 1'b0;
      launch(5, 2);
      for (int k = 0; k < 3; k++) begin
         chk(busy === 1'b0 && tok_valid === 1'b0, "R6 no launch disconnected",
             int'(busy), 0);
         @(negedge clk);
      end
      port_connected = 1'b1;

      // sweep budgets, failure counts, final codes and channels
      for (int r = 0; r < 8; r++)
         for (int ne = 0; ne <= r + 1; ne++)
            run_seq(r, (r * 3 + ne) % 16, ne, (r + ne) % 3, 1'b0);

      // R7 writes while busy
      run_seq(3, 6, 2, 0, 1'b1);
      run_seq(1, 15, 2, 1, 1'b1);

      // R8 transmitter stalls
      tok_ready = 1'b0;
      launch(2, 9);
      for (int k = 0; k < 3; k++) begin
         chk_tok(1'b0, 9, "R8 ext held");
         @(negedge clk);
      end
      tok_ready = 1'b1;
      @(negedge clk);
      tok_ready = 1'b0;
      for (int k = 0; k < 2; k++) begin
         chk_tok(1'b1, 9, "R8 lpm held");
         @(negedge clk);
      end
      tok_ready = 1'b1;
      @(negedge clk);
      rsp_valid = 1'b1; rsp_code = 3'd2;
      @(negedge clk);
      rsp_valid = 1'b0;
      chk(done === 1'b1 && result === 2'd2, "R2 stall after held tokens", int'(result), 2);
      @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule